// File: doc/BRIEF.md
# Cheat Cartridge Patch Controller

This block sits on a 16-bit host bus in front of a cartridge ROM and lets a cheat cartridge override up to four ROM words. The host writes a small bank of word registers that hold four patch records (a data word plus a split address) and a mode word. A three-position switch chooses whether the recorded patches are applied (on), not applied (off), or held in a training position that also makes a soft reset wipe the board's state.

Reads are substituted on the fly. The block sees every ROM read address together with the word the ROM returns. When patching is on and the address matches a latched patch, it returns the patch word instead. At power-up the lowest 64 KiB of the address space belongs to the board's own firmware ROM. Once the firmware has stored the all-ones mode word, the block flips its ROM-select output and the cartridge owns that window from then on. A byte-write helper for the board's companion RAM is included, since that RAM has no low-byte strobe.

Reads are combinational and have no handshake: the bus owns the timing, and no back-pressure is possible or needed. The board variant (basic or pro) is chosen by a parameter.

Top module: `cheat_patch_ctrl`

## Requirements
- R1: The register bank holds 13 words, selected by the bus word address bits [15:1] (`reg_addr_i`). A write whose word offset is 13 or more changes no register.
- R2: Patch record k (k = 0..3) takes its data word from register 0, 4, 7 or 10. Its address-low and address-high registers are the next two registers: (1,2), (5,6), (8,9) and (11,12).
- R3: A patch matches the read word address `{high[13:8], low[15:0]}`. All other bits of the high register are ignored. A read with address bit 23 set never matches.
- R4: After a register write that leaves register 3 at 0xFFFF, `rom_sel_o` is 1 from the next cycle on. Only a clearing reset returns it to 0.
- R5: When patching is already on and a register write leaves register 3 at 0xFFFF, all four patch records are re-latched from the register contents after that write.
- R6: Patch records are captured only on entry to the on state, or as in R5. Other register writes made while patching is on do not change what a read returns.
- R7: In the off or trainer position no read is substituted. Returning to on applies the current register contents.
- R8: With `BASIC_BOARD`=1, a trainer request acts as off. A soft reset then clears nothing.
- R9: A hard reset (`rst_n` low) clears all registers and patches, selects off and drives `rom_sel_o` to 0. A soft reset clears the registers, the patches and `rom_sel_o` only while the state is trainer; in any other state it has no effect.
- R10: With `ram_byte_i`=1, `ram_wdata_o` carries the low byte of `ram_wdata_i` in both halves. Otherwise it passes `ram_wdata_i` unchanged.
- R11: If several patches match one address, the one with the lowest index supplies the data.
- R12: `switch_i` is coded 00 = off, 01 = on, 10 = trainer, 11 = keep the present state. The state changes only at a clock edge.
- R13: While `rom_sel_o` is 0, reads whose address bits [23:16] are all zero (firmware window) return `rom_rdata_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset request |
| switch_i | input | 2 | Switch position (see R12) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 15 | Word address bits [15:1] within the register window |
| reg_wdata_i | input | 16 | Register write data |
| rd_addr_i | input | 23 | ROM read word address, bits [23:1] |
| rom_rdata_i | input | 16 | Word returned by the selected ROM |
| rd_data_o | output | 16 | Read data after substitution |
| rom_sel_o | output | 1 | 0: firmware ROM owns the low window, 1: cartridge ROM |
| ram_byte_i | input | 1 | Companion RAM access is a byte write |
| ram_wdata_i | input | 16 | Companion RAM write data from the bus |
| ram_wdata_o | output | 16 | Word to store in the companion RAM |

## Verification
The read path is probed with a fixed set of addresses after every change of state. The set contains two patch addresses and two near misses: an address one word off, and an address that differs only in bit 23. It also contains a firmware-window address and an address shared by two patch records. Together these separate a wrong address build, a wrong slot priority and a leak into the firmware window. Register writes made while patching is on are compared before and after the all-ones mode word, which separates a latch that is captured once from one that tracks the registers. A second instance built as the basic board receives the same stimulus. The soft reset issued in the trainer position must therefore clear one instance and leave the other unchanged.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef enum logic [1:0] {
    SW_OFF     = 2'b00,
    SW_ON      = 2'b01,
    SW_TRAINER = 2'b10,
    SW_HOLD    = 2'b11
  } sw_e;

  localparam int MODE_IDX = 3;

  // register index of the data word of patch record k
  function automatic int data_idx(input int k);
    return (k == 0) ? 0 : 3 * k + 1;
  endfunction
endpackage

// File: rtl/cpr_regfile.sv
module cpr_regfile #(
  parameter int NUM_PATCH = 4,
  parameter int DATA_W    = 16,
  parameter int OFF_W     = 15,
  parameter int HI_LSB    = 8,
  parameter int HI_W      = 6,
  localparam int NUM_REGS = 3 * NUM_PATCH + 1,
  localparam int WA_W     = HI_W + DATA_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic                                wr_en,
  input  logic [OFF_W-1:0]                    wr_off,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_PATCH-1:0][DATA_W-1:0]    slot_data,
  output logic [NUM_PATCH-1:0][WA_W-1:0]      slot_waddr,
  output logic                                mode_hit
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q, regs_d;
  logic wr_hit;

  assign wr_hit = wr_en && !clr && (wr_off < OFF_W'(NUM_REGS));

  always_comb begin
    regs_d = regs_q;
    if (clr) begin
      regs_d = '0;
    end else if (wr_hit) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_off == OFF_W'(i)) regs_d[i] = wr_data;
      end
    end
  end

  assign mode_hit = wr_hit && (regs_d[cpr_pkg::MODE_IDX] == {DATA_W{1'b1}});

  for (genvar k = 0; k < NUM_PATCH; k++) begin : g_view
    localparam int DI = cpr_pkg::data_idx(k);
    assign slot_data[k]  = regs_d[DI];
    assign slot_waddr[k] = {regs_d[DI+2][HI_LSB+HI_W-1:HI_LSB], regs_d[DI+1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end
endmodule

// File: rtl/cpr_mode_ctrl.sv
module cpr_mode_ctrl #(
  parameter bit BASIC_BOARD = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic [1:0] sw_req,
  input  logic       mode_hit,
  output logic       clr,
  output logic       latch_en,
  output logic       patch_on,
  output logic       cart_sel
);
  import cpr_pkg::*;

  sw_e state_q, state_d, eff;

  always_comb begin
    unique case (sw_e'(sw_req))
      SW_OFF:     eff = SW_OFF;
      SW_ON:      eff = SW_ON;
      SW_TRAINER: eff = BASIC_BOARD ? SW_OFF : SW_TRAINER;
      default:    eff = state_q;
    endcase
  end

  assign clr      = soft_rst && (state_q == SW_TRAINER);
  assign state_d  = clr ? state_q : eff;
  assign latch_en = !clr && (((eff == SW_ON) && (state_q != SW_ON)) ||
                             (mode_hit && (state_q == SW_ON)));
  assign patch_on = (state_q == SW_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SW_OFF;
      cart_sel <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr)           cart_sel <= 1'b0;
      else if (mode_hit) cart_sel <= 1'b1;
    end
  end
endmodule

// File: rtl/cpr_patch_slot.sv
module cpr_patch_slot #(
  parameter int DATA_W = 16,
  parameter int WA_W   = 22,
  parameter int RA_W   = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              latch_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [WA_W-1:0]   waddr_in,
  input  logic [RA_W-1:0]   rd_waddr,
  output logic              hit,
  output logic [DATA_W-1:0] pdata
);
  logic [WA_W-1:0] waddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      pdata   <= '0;
    end else if (clr) begin
      waddr_q <= '0;
      pdata   <= '0;
    end else if (latch_en) begin
      waddr_q <= waddr_in;
      pdata   <= data_in;
    end
  end

  assign hit = (rd_waddr == RA_W'(waddr_q));
endmodule

// File: rtl/cpr_read_sel.sv
module cpr_read_sel #(
  parameter int NUM_PATCH = 4,
  parameter int DATA_W    = 16
) (
  input  logic                             en,
  input  logic [NUM_PATCH-1:0]             hits,
  input  logic [NUM_PATCH-1:0][DATA_W-1:0] pdata,
  input  logic [DATA_W-1:0]                rom_data,
  output logic [DATA_W-1:0]                out_data
);
  always_comb begin
    out_data = rom_data;
    if (en) begin
      for (int i = NUM_PATCH - 1; i >= 0; i--) begin
        if (hits[i]) out_data = pdata[i];
      end
    end
  end
endmodule

// File: rtl/cheat_patch_ctrl.sv
module cheat_patch_ctrl #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int WIN_W       = 16,
  parameter int NUM_PATCH   = 4,
  parameter int HI_LSB      = 8,
  parameter int HI_W        = 6,
  parameter bit BASIC_BOARD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic [1:0]        switch_i,
  input  logic              reg_wr_i,
  input  logic [WIN_W-1:1]  reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [ADDR_W-1:1] rd_addr_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rom_sel_o,
  input  logic              ram_byte_i,
  input  logic [DATA_W-1:0] ram_wdata_i,
  output logic [DATA_W-1:0] ram_wdata_o
);
  localparam int OFF_W = WIN_W - 1;
  localparam int RA_W  = ADDR_W - 1;
  localparam int WA_W  = HI_W + DATA_W;

  logic clr, latch_en, patch_on, mode_hit, low_win, sub_en;
  logic [NUM_PATCH-1:0][DATA_W-1:0] slot_data, slot_pdata;
  logic [NUM_PATCH-1:0][WA_W-1:0]   slot_waddr;
  logic [NUM_PATCH-1:0]             slot_hit;

  cpr_regfile #(
    .NUM_PATCH(NUM_PATCH), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .HI_LSB(HI_LSB), .HI_W(HI_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(reg_wr_i), .wr_off(reg_addr_i), .wr_data(reg_wdata_i),
    .slot_data(slot_data), .slot_waddr(slot_waddr), .mode_hit(mode_hit)
  );

  cpr_mode_ctrl #(.BASIC_BOARD(BASIC_BOARD)) u_mode (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .sw_req(switch_i),
    .mode_hit(mode_hit), .clr(clr), .latch_en(latch_en),
    .patch_on(patch_on), .cart_sel(rom_sel_o)
  );

  for (genvar k = 0; k < NUM_PATCH; k++) begin : g_slot
    cpr_patch_slot #(.DATA_W(DATA_W), .WA_W(WA_W), .RA_W(RA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(clr), .latch_en(latch_en),
      .data_in(slot_data[k]), .waddr_in(slot_waddr[k]),
      .rd_waddr(rd_addr_i), .hit(slot_hit[k]), .pdata(slot_pdata[k])
    );
  end

  assign low_win = (rd_addr_i[ADDR_W-1:WIN_W] == '0);
  assign sub_en  = patch_on && (rom_sel_o || !low_win);

  cpr_read_sel #(.NUM_PATCH(NUM_PATCH), .DATA_W(DATA_W)) u_sel (
    .en(sub_en), .hits(slot_hit), .pdata(slot_pdata),
    .rom_data(rom_rdata_i), .out_data(rd_data_o)
  );

  // companion RAM has no low-byte strobe: a byte lands in every byte lane
  assign ram_wdata_o = ram_byte_i ? {(DATA_W/8){ram_wdata_i[7:0]}} : ram_wdata_i;
endmodule

// File: rtl/cpr_checks.sv
module cpr_checks #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int WIN_W       = 16,
  parameter bit BASIC_BOARD = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst_i,
  input logic [1:0]        switch_i,
  input logic [ADDR_W-1:1] rd_addr_i,
  input logic [DATA_W-1:0] rom_rdata_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rom_sel_o,
  input logic              ram_byte_i,
  input logic [DATA_W-1:0] ram_wdata_i,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic              patch_on,
  input logic              clr
);
  // R7: nothing is substituted unless patching is on
  a_r7_passthru_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !patch_on |-> rd_data_o == rom_rdata_i);

  // R4: the cartridge select only drops after a soft reset request
  a_r4_romsel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_sel_o) |-> $past(soft_rst_i));

  // R13: the firmware window is never patched
  a_r13_firmware_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel_o && rd_addr_i[ADDR_W-1:WIN_W] == '0) |-> rd_data_o == rom_rdata_i);

  // R10: byte writes carry the low byte in both lanes
  a_r10_ram_dup: assert property (@(posedge clk) disable iff (!rst_n)
    ram_byte_i |-> (ram_wdata_o[15:8] == ram_wdata_i[7:0] &&
                    ram_wdata_o[7:0]  == ram_wdata_i[7:0]));

  // R8: the basic board never performs the trainer-state clear
  a_r8_basic_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (BASIC_BOARD && soft_rst_i) |-> !clr);

  // R12: patching turns on only after an on request
  a_r12_on_by_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(patch_on) |-> $past(switch_i) == 2'b01);
endmodule

bind cheat_patch_ctrl cpr_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .BASIC_BOARD(BASIC_BOARD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .switch_i(switch_i),
  .rd_addr_i(rd_addr_i), .rom_rdata_i(rom_rdata_i), .rd_data_o(rd_data_o),
  .rom_sel_o(rom_sel_o), .ram_byte_i(ram_byte_i), .ram_wdata_i(ram_wdata_i),
  .ram_wdata_o(ram_wdata_o), .patch_on(patch_on), .clr(clr)
);

// File: tb/cheat_patch_ctrl_tb.sv
module cheat_patch_ctrl_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic soft_rst = 0;
  logic [1:0] sw = 2'b00;
  logic reg_wr = 0;
  logic [15:1] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [23:1] rd_addr = '0;
  logic [15:0] rom_rdata = '0;
  logic ram_byte = 0;
  logic [15:0] ram_wdata = '0;
  logic [15:0] rd_a, rd_b, ram_a, ram_b;
  logic sel_a, sel_b;

  int nchk = 0, nerr = 0;
  string tag = "R9";
  bit done = 0;

  always #4 clk = ~clk;

  cheat_patch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .switch_i(sw),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .rd_addr_i(rd_addr), .rom_rdata_i(rom_rdata), .rd_data_o(rd_a),
    .rom_sel_o(sel_a), .ram_byte_i(ram_byte), .ram_wdata_i(ram_wdata),
    .ram_wdata_o(ram_a));

  cheat_patch_ctrl #(.BASIC_BOARD(1'b1)) u_basic (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .switch_i(sw),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .rd_addr_i(rd_addr), .rom_rdata_i(rom_rdata), .rd_data_o(rd_b),
    .rom_sel_o(sel_b), .ram_byte_i(ram_byte), .ram_wdata_i(ram_wdata),
    .ram_wdata_o(ram_b));

  // behavioural reference: index 0 = pro board, 1 = basic board
  int mregs [2][13];
  int mpd [2][4];
  int mpa [2][4];
  int mst [2];
  bit mcart [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int r = 0; r < 13; r++) mregs[b][r] = 0;
        for (int k = 0; k < 4; k++) begin mpd[b][k] = 0; mpa[b][k] = 0; end
        mst[b] = 0; mcart[b] = 0;
      end
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (soft_rst && mst[b] == 2) begin
          for (int r = 0; r < 13; r++) mregs[b][r] = 0;
          for (int k = 0; k < 4; k++) begin mpd[b][k] = 0; mpa[b][k] = 0; end
          mcart[b] = 0;
        end else begin
          int nr [13];
          int eff;
          bit hit;
          bit lat;
          for (int r = 0; r < 13; r++) nr[r] = mregs[b][r];
          hit = 0;
          if (reg_wr && int'(reg_addr) < 13) begin
            nr[int'(reg_addr)] = int'(reg_wdata);
            hit = (nr[3] == 'hFFFF);
          end
          case (sw)
            2'b00: eff = 0;
            2'b01: eff = 1;
            2'b10: eff = (b == 1) ? 0 : 2;
            default: eff = mst[b];
          endcase
          lat = (eff == 1 && mst[b] != 1) || (hit && mst[b] == 1);
          if (lat) begin
            for (int k = 0; k < 4; k++) begin
              int di;
              di = (k == 0) ? 0 : 3 * k + 1;
              mpd[b][k] = nr[di];
              mpa[b][k] = (((nr[di+2] >> 8) & 'h3F) << 16) | nr[di+1];
            end
          end
          for (int r = 0; r < 13; r++) mregs[b][r] = nr[r];
          if (hit) mcart[b] = 1;
          mst[b] = eff;
        end
      end
    end
  end

  function automatic int exp_rd(input int b);
    int wa;
    wa = int'(rd_addr);
    if (mst[b] == 1 && !(wa < 'h8000 && !mcart[b])) begin
      for (int k = 0; k < 4; k++) if (wa == mpa[b][k]) return mpd[b][k];
    end
    return int'(rom_rdata);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(tag, "rd_data pro", int'(rd_a), exp_rd(0));
    chk(tag, "rd_data basic", int'(rd_b), exp_rd(1));
    chk(tag, "rom_sel pro", int'(sel_a), int'(mcart[0]));
    chk(tag, "rom_sel basic", int'(sel_b), int'(mcart[1]));
    chk("R10", "ram_wdata", int'(ram_a),
        ram_byte ? ((int'(ram_wdata[7:0]) << 8) | int'(ram_wdata[7:0])) : int'(ram_wdata));
  endtask

  task automatic wr(input int off, input int data);
    reg_wr = 1; reg_addr = 15'(off); reg_wdata = 16'(data);
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input int byte_addr);
    rd_addr = 23'(byte_addr >> 1);
    rom_rdata = 16'(byte_addr >> 1) ^ 16'hA5C3;
    tick();
  endtask

  // probes: R13 window, shared R11 address, slot 2, near miss, bit-23 alias, high window
  task automatic sweep();
    rd('h000200); rd('h030000); rd('h7E0020); rd('h7E0022);
    rd('hFE0020); rd('h010200); rd('h000000);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    tag = "R9"; tick(); tick(); rst_n = 1; tick(); sweep();
    tag = "R1";
    wr(13, 'hDEAD); wr(16, 'hBEEF); wr('h7FFF, 'hFFFF);
    tag = "R2";
    wr(0, 'h1111); wr(1, 'h0100); wr(2, 'h0000);
    wr(4, 'h2222); wr(5, 'h8000); wr(6, 'hC1FF);
    wr(7, 'h3333); wr(8, 'h0010); wr(9, 'h3F00);
    wr(10, 'h4444); wr(11, 'h8000); wr(12, 'h0100);
    tag = "R12"; sw = 2'b01; tick(); sw = 2'b11; tick();
    tag = "R2"; sweep();
    tag = "R11"; rd('h030000);
    tag = "R3"; rd('hFE0020); rd('h7E0022);
    tag = "R6"; wr(0, 'h5555); wr(4, 'h6666); sweep();
    tag = "R4"; wr(3, 'hFFFF); sweep();
    tag = "R5"; wr(7, 'h7777); sweep();
    tag = "R9"; soft_rst = 1; tick(); soft_rst = 0; sweep();
    tag = "R7"; sw = 2'b00; tick(); sweep();
    sw = 2'b01; tick(); sweep();
    sw = 2'b10; tick(); sweep();
    tag = "R8"; sw = 2'b11; soft_rst = 1; tick(); soft_rst = 0; sweep();
    tag = "R12"; sw = 2'b01; tick(); sw = 2'b11; sweep();
    tag = "R13"; rd('h000200); rd('h000000);
    tag = "R10";
    ram_byte = 1; ram_wdata = 16'h12AB; tick();
    ram_byte = 0; tick();
    ram_byte = 1; ram_wdata = 16'hFF00; tick(); ram_byte = 0;
    tag = "R9"; rst_n = 0; tick(); tick(); rst_n = 1; tick(); sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule